// File: doc/BRIEF.md
# Dual-Target Interrupt Message Controller

The controller gathers up to eleven level-sensitive interrupt lines. It turns each new assertion into a posted memory-write request toward a bus-master engine. It keeps two per-line records. One is a live image that follows the present level. The other is a sticky pending record that remembers every rising level until software clears it. A line that rises while it is enabled in the mask queues one message. The message goes to one of two target registers, chosen per line by a select register. The outbound address is the chosen target with its five low bits forced to zero, and the outbound data is those five low bits.

The line inputs come from three kinds of source. PCI device-function interrupt inputs are folded onto the four low lines by slot number. A serial-port interrupt feeds the highest line. General-purpose inputs feed any line directly. Software reaches eight 32-bit registers through a single-cycle read/write port. Requests wait in a per-line send vector while an earlier write is still unacknowledged, and they are served lowest line first.

Top module: `irqmsg_ctrl`

## Requirements
- R1: After reset every register reads zero and `msg_req_o` is low, so no message can be sent until the mask is written.
- R2: On a clock edge where a line is high and its live bit is low, the edge sets both the live bit and the pending bit. When the line goes low, only the live bit clears and the pending bit stays set.
- R3: Reading the pending register (index 4) returns its value and clears it at that edge. Writing it clears it whatever the data. A line that rises on the same edge as a clear is still recorded as pending.
- R4: The live register (index 5) and both request views (indices 6 and 7) are read-only, and writing them leaves them unchanged.
- R5: Request view 0 (index 6) reads live & mask & ~select, and request view 1 (index 7) reads live & mask & select.
- R6: A newly risen line whose mask bit (index 2) is set produces exactly one write request, which appears two clock edges after the line is first sampled high. A masked-off line produces none, and a line held high does not retrigger.
- R7: The message for line n uses target 1 (index 1) when bit n of the select register (index 3) is 1, and target 0 (index 0) otherwise. The target is read when the message is issued.
- R8: The request address is the target value with bits 4:0 cleared, and the request data is the target's bits 4:0, zero-extended.
- R9: `msg_req_o` stays high, with its address and data unchanged, until a cycle in which `msg_ack_i` is high.
- R10: Triggers that arrive while a request is outstanding wait per line and are issued lowest line first, one per acknowledge. A second trigger of a line that is still waiting merges into the one already queued.
- R11: PCI device-function input d drives line ((d >> 3) & 3), and the serial input drives line 10. Each line is the OR of all its sources.
- R12: Register indices are 0 target 0, 1 target 1, 2 mask, 3 select, 4 pending, 5 live, 6 view 0 and 7 view 1. Targets, mask and select hold all 32 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ext_irq_i | input | 11 | General-purpose interrupt lines, one per line |
| pci_irq_i | input | 32 | PCI interrupts indexed by device/function number |
| serial_irq_i | input | 1 | Serial-port interrupt, feeds line 10 |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (clears pending on read) |
| reg_addr_i | input | 3 | Register index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, valid in the strobe cycle |
| msg_req_o | output | 1 | Outbound write request |
| msg_ack_i | input | 1 | Acknowledge from the write engine |
| msg_addr_o | output | 32 | Outbound write address |
| msg_data_o | output | 32 | Outbound write data |

## Verification
The assertions assume that all interrupt sources are synchronous to `clk_i`. They also assume that `msg_ack_i` is meaningful only while a request is high, and that a read and a write strobe never hit the pending register in the same cycle. The bench drives every input at the falling edge, so each input holds steady across the rising edge. It raises an acknowledge only through a bench model that tracks the outstanding request, and it issues register accesses one at a time. The random phase leaves the targets, mask and select fixed while the lines toggle. This lets the bench model check every cycle's request against the issue-time target choice.

// File: rtl/irqmsg_pkg.sv
`timescale 1ns/1ps
package irqmsg_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned OFS_W  = 5;   // low bits of a target that carry data
  localparam int unsigned IDX_W  = 3;

  typedef enum logic [IDX_W-1:0] {
    IDX_TGT0  = 3'd0,
    IDX_TGT1  = 3'd1,
    IDX_MASK  = 3'd2,
    IDX_SEL   = 3'd3,
    IDX_PEND  = 3'd4,
    IDX_LIVE  = 3'd5,
    IDX_VIEW0 = 3'd6,
    IDX_VIEW1 = 3'd7
  } reg_idx_e;
endpackage

// File: rtl/irqmsg_src_map.sv
`timescale 1ns/1ps
module irqmsg_src_map #(
  parameter int unsigned NUM_LINES = 11,
  parameter int unsigned NUM_DEVFN = 32
) (
  input  logic [NUM_LINES-1:0] ext_irq_i,
  input  logic [NUM_DEVFN-1:0] pci_irq_i,
  input  logic                 serial_irq_i,
  output logic [NUM_LINES-1:0] line_o
);
  localparam int unsigned PCI_LINES   = 4;
  localparam int unsigned SERIAL_LINE = NUM_LINES - 1;

  function automatic logic [NUM_DEVFN-1:0] slot_sel(input int unsigned l);
    logic [NUM_DEVFN-1:0] m;
    m = '0;
    for (int unsigned d = 0; d < NUM_DEVFN; d++) begin
      m[d] = (((d >> 3) & 3) == l);
    end
    return m;
  endfunction

  logic [PCI_LINES-1:0] pci_line;

  for (genvar l = 0; l < PCI_LINES; l++) begin : g_pci
    localparam logic [NUM_DEVFN-1:0] SLOT_M = slot_sel(l);
    assign pci_line[l] = |(pci_irq_i & SLOT_M);
  end

  always_comb begin
    line_o = ext_irq_i;
    line_o[PCI_LINES-1:0] = line_o[PCI_LINES-1:0] | pci_line;
    line_o[SERIAL_LINE] = line_o[SERIAL_LINE] | serial_irq_i;
  end
endmodule

// File: rtl/irqmsg_regs.sv
`timescale 1ns/1ps
module irqmsg_regs
  import irqmsg_pkg::*;
#(
  parameter int unsigned NUM_LINES = 11
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] line_i,
  input  logic                 we_i,
  input  logic                 re_i,
  input  logic [IDX_W-1:0]     addr_i,
  input  logic [WORD_W-1:0]    wdata_i,
  output logic [WORD_W-1:0]    rdata_o,
  output logic [NUM_LINES-1:0] trig_o,
  output logic [NUM_LINES-1:0] sel_o,
  output logic [WORD_W-1:0]    tgt0_o,
  output logic [WORD_W-1:0]    tgt1_o
);
  logic [WORD_W-1:0]    tgt0_q, tgt1_q, mask_q, sel_q;
  logic [NUM_LINES-1:0] live_q, pend_q;
  logic [NUM_LINES-1:0] rise, mask_l, sel_l;
  logic                 pend_clr;

  function automatic logic [WORD_W-1:0] widen(input logic [NUM_LINES-1:0] v);
    logic [WORD_W-1:0] r;
    r = '0;
    r[NUM_LINES-1:0] = v;
    return r;
  endfunction

  assign mask_l   = mask_q[NUM_LINES-1:0];
  assign sel_l    = sel_q[NUM_LINES-1:0];
  assign rise     = line_i & ~live_q;
  assign trig_o   = rise & mask_l;
  assign sel_o    = sel_l;
  assign tgt0_o   = tgt0_q;
  assign tgt1_o   = tgt1_q;
  assign pend_clr = (we_i || re_i) && (addr_i == IDX_PEND);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt0_q <= '0;
      tgt1_q <= '0;
      mask_q <= '0;
      sel_q  <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        IDX_TGT0: tgt0_q <= wdata_i;
        IDX_TGT1: tgt1_q <= wdata_i;
        IDX_MASK: mask_q <= wdata_i;
        IDX_SEL:  sel_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= '0;
      pend_q <= '0;
    end else begin
      live_q <= line_i;
      pend_q <= (pend_clr ? '0 : pend_q) | rise;  // new rises survive a clear
    end
  end

  always_comb begin
    unique case (addr_i)
      IDX_TGT0:  rdata_o = tgt0_q;
      IDX_TGT1:  rdata_o = tgt1_q;
      IDX_MASK:  rdata_o = mask_q;
      IDX_SEL:   rdata_o = sel_q;
      IDX_PEND:  rdata_o = widen(pend_q);
      IDX_LIVE:  rdata_o = widen(live_q);
      IDX_VIEW0: rdata_o = widen(live_q & mask_l & ~sel_l);
      IDX_VIEW1: rdata_o = widen(live_q & mask_l & sel_l);
      default:   rdata_o = '0;
    endcase
  end

  assert_pend_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rise) |=> ((pend_q & $past(rise)) == $past(rise)));

  assert_pend_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_clr && rise == '0) |=> (pend_q == '0));

  assert_live_ro_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == IDX_LIVE) |=> (live_q == $past(line_i)));
endmodule

// File: rtl/irqmsg_sender.sv
`timescale 1ns/1ps
module irqmsg_sender
  import irqmsg_pkg::*;
#(
  parameter int unsigned NUM_LINES = 11
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] trig_i,
  input  logic [NUM_LINES-1:0] sel_i,
  input  logic [WORD_W-1:0]    tgt0_i,
  input  logic [WORD_W-1:0]    tgt1_i,
  input  logic                 ack_i,
  output logic                 req_o,
  output logic [WORD_W-1:0]    addr_o,
  output logic [WORD_W-1:0]    data_o
);
  logic [NUM_LINES-1:0] send_q, grant;
  logic                 req_q, issue, pick_hi;
  logic [WORD_W-1:0]    addr_q, data_q, tgt;

  // lowest-numbered waiting line wins
  always_comb begin
    grant   = '0;
    pick_hi = 1'b0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (send_q[i]) begin
        grant   = '0;
        grant[i] = 1'b1;
        pick_hi = sel_i[i];
      end
    end
  end

  assign issue = (!req_q || ack_i) && (|send_q);
  assign tgt   = pick_hi ? tgt1_i : tgt0_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      send_q <= '0;
      req_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      send_q <= (send_q & ~(issue ? grant : '0)) | trig_i;
      if (issue) begin
        req_q  <= 1'b1;
        addr_q <= {tgt[WORD_W-1:OFS_W], {OFS_W{1'b0}}};
        data_q <= {{(WORD_W-OFS_W){1'b0}}, tgt[OFS_W-1:0]};
      end else if (ack_i) begin
        req_q  <= 1'b0;
      end
    end
  end

  assign req_o  = req_q;
  assign addr_o = addr_q;
  assign data_o = data_q;

  assert_req_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && !ack_i) |=> (req_q && $stable(addr_q) && $stable(data_q)));

  assert_queue_keep_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && !ack_i) |=> ((send_q & $past(send_q)) == $past(send_q)));

  assert_req_source_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_q) |-> $past(|send_q));
endmodule

// File: rtl/irqmsg_ctrl.sv
`timescale 1ns/1ps
module irqmsg_ctrl
  import irqmsg_pkg::*;
#(
  parameter int unsigned NUM_LINES = 11,
  parameter int unsigned NUM_DEVFN = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] ext_irq_i,
  input  logic [NUM_DEVFN-1:0] pci_irq_i,
  input  logic                 serial_irq_i,
  input  logic                 reg_we_i,
  input  logic                 reg_re_i,
  input  logic [2:0]           reg_addr_i,
  input  logic [31:0]          reg_wdata_i,
  output logic [31:0]          reg_rdata_o,
  output logic                 msg_req_o,
  input  logic                 msg_ack_i,
  output logic [31:0]          msg_addr_o,
  output logic [31:0]          msg_data_o
);
  logic [NUM_LINES-1:0] line, trig, sel;
  logic [WORD_W-1:0]    tgt0, tgt1;

  irqmsg_src_map #(.NUM_LINES(NUM_LINES), .NUM_DEVFN(NUM_DEVFN)) u_map (
    .ext_irq_i    (ext_irq_i),
    .pci_irq_i    (pci_irq_i),
    .serial_irq_i (serial_irq_i),
    .line_o       (line)
  );

  irqmsg_regs #(.NUM_LINES(NUM_LINES)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .line_i  (line),
    .we_i    (reg_we_i),
    .re_i    (reg_re_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .trig_o  (trig),
    .sel_o   (sel),
    .tgt0_o  (tgt0),
    .tgt1_o  (tgt1)
  );

  irqmsg_sender #(.NUM_LINES(NUM_LINES)) u_send (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (trig),
    .sel_i  (sel),
    .tgt0_i (tgt0),
    .tgt1_i (tgt1),
    .ack_i  (msg_ack_i),
    .req_o  (msg_req_o),
    .addr_o (msg_addr_o),
    .data_o (msg_data_o)
  );
endmodule

// File: tb/irqmsg_ctrl_tb.sv
`timescale 1ns/1ps
module irqmsg_ctrl_tb;
  localparam int NL = 11;
  localparam int ND = 32;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [NL-1:0] ext_irq = '0;
  logic [ND-1:0] pci_irq = '0;
  logic          serial_irq = 0;
  logic          we = 0, re = 0;
  logic [2:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          msg_req;
  logic          ack = 1;
  logic [31:0]   msg_addr, msg_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irqmsg_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ext_irq_i(ext_irq), .pci_irq_i(pci_irq),
    .serial_irq_i(serial_irq), .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .msg_req_o(msg_req),
    .msg_ack_i(ack), .msg_addr_o(msg_addr), .msg_data_o(msg_data)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    we = 1; addr = a; wdata = d;
    step();
    we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    re = 1; addr = a;
    #1 d = rdata;
    step();
    re = 0;
  endtask

  function automatic logic [31:0] wider(input logic [NL-1:0] v);
    return {{(32-NL){1'b0}}, v};
  endfunction

  // bench model for random phase
  logic [NL-1:0] m_live, m_pend, m_send, m_mask, m_sel;
  logic [31:0]   m_t0, m_t1, m_addr, m_data;
  logic          m_req;

  task automatic model_edge(input logic [NL-1:0] l, input logic a);
    logic [NL-1:0] trig;
    trig = l & ~m_live & m_mask;
    if ((!m_req || a) && m_send != '0) begin
      for (int i = 0; i < NL; i++) begin
        if (m_send[i]) begin
          logic [31:0] t;
          t = m_sel[i] ? m_t1 : m_t0;
          m_addr = t & 32'hFFFF_FFE0;
          m_data = t & 32'h1F;
          m_send[i] = 1'b0;
          break;
        end
      end
      m_req = 1;
    end else if (a) begin
      m_req = 0;
    end
    m_send = m_send | trig;
    m_pend = m_pend | (l & ~m_live);
    m_live = l;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    step();

    chk("R1 req after reset", {31'd0, msg_req}, 32'd0);
    for (int i = 0; i < 8; i++) begin
      rd(3'(i), v);
      chk("R1 reg zero after reset", v, 32'd0);
    end

    wr(3'd0, 32'h1234_5667);
    wr(3'd1, 32'hABCD_EF13);
    wr(3'd2, 32'h0000_07FF);
    wr(3'd3, 32'h0000_00F0);
    rd(3'd0, v); chk("R12 target0", v, 32'h1234_5667);
    rd(3'd1, v); chk("R12 target1", v, 32'hABCD_EF13);
    rd(3'd2, v); chk("R12 mask", v, 32'h0000_07FF);
    rd(3'd3, v); chk("R12 select", v, 32'h0000_00F0);

    // single trigger to target 0, held without acknowledge
    ack = 0;
    ext_irq = NL'(1 << 2);
    step(); step();
    chk("R6 req issued", {31'd0, msg_req}, 32'd1);
    chk("R8 addr t0", msg_addr, 32'h1234_5660);
    chk("R8 data t0", msg_data, 32'h0000_0007);
    step(); step(); step();
    chk("R9 req held", {31'd0, msg_req}, 32'd1);
    chk("R9 addr held", msg_addr, 32'h1234_5660);
    ack = 1;
    step();
    chk("R9 req drops on ack", {31'd0, msg_req}, 32'd0);
    step(); step(); step();
    chk("R6 held level no retrigger", {31'd0, msg_req}, 32'd0);
    ext_irq = '0;
    step();

    // line with select bit set goes to target 1
    ack = 0;
    ext_irq = NL'(1 << 5);
    step(); step();
    chk("R7 req line5", {31'd0, msg_req}, 32'd1);
    chk("R7 addr t1", msg_addr, 32'hABCD_EF00);
    chk("R8 data t1", msg_data, 32'h0000_0013);
    ack = 1;
    step();
    chk("R9 req drops", {31'd0, msg_req}, 32'd0);
    ext_irq = '0;
    step();

    // queued order and merge
    ack = 0;
    ext_irq = NL'((1 << 6) | (1 << 2));
    step(); step();
    chk("R10 first lowest line", msg_data, 32'h0000_0007);
    ext_irq = NL'(1 << 2);
    step();
    ext_irq = NL'((1 << 6) | (1 << 2));
    step();
    ack = 1;
    step();
    chk("R10 second req", {31'd0, msg_req}, 32'd1);
    chk("R10 second from line6", msg_data, 32'h0000_0013);
    step();
    chk("R10 merged retrigger", {31'd0, msg_req}, 32'd0);
    ext_irq = '0;
    step();

    // masked line and pending behaviour
    wr(3'd2, 32'h0000_06FF);
    rd(3'd4, v);
    ext_irq = NL'(1 << 8);
    step(); step(); step();
    chk("R6 masked no req", {31'd0, msg_req}, 32'd0);
    rd(3'd4, v); chk("R2 pend set", v, 32'h0000_0100);
    rd(3'd4, v); chk("R3 read clears", v, 32'd0);
    rd(3'd5, v); chk("R2 live set", v, 32'h0000_0100);
    ext_irq = NL'(1 << 9);
    step();
    ext_irq = '0;
    step();
    rd(3'd5, v); chk("R2 live clears on fall", v, 32'd0);
    rd(3'd4, v); chk("R2 pend kept on fall", v, 32'h0000_0200);
    ext_irq = NL'(1 << 9);
    step();
    ext_irq = '0;
    step();
    wr(3'd4, 32'd0);
    rd(3'd4, v); chk("R3 write clears", v, 32'd0);
    ext_irq = NL'(1 << 7);
    rd(3'd4, v); chk("R3 pend before same-cycle rise", v, 32'd0);
    rd(3'd4, v); chk("R3 rise survives clear", v, 32'h0000_0080);
    ext_irq = '0;
    step();

    // request views and read-only registers
    wr(3'd2, 32'h0000_07FF);
    ext_irq = NL'(11'h0C3);
    step();
    rd(3'd6, v); chk("R5 view0", v, 32'h0000_0003);
    rd(3'd7, v); chk("R5 view1", v, 32'h0000_00C0);
    wr(3'd5, 32'h0000_FFFF);
    wr(3'd6, 32'h0000_FFFF);
    wr(3'd7, 32'h0000_0000);
    rd(3'd5, v); chk("R4 live read-only", v, 32'h0000_00C3);
    rd(3'd6, v); chk("R4 view0 read-only", v, 32'h0000_0003);
    rd(3'd7, v); chk("R4 view1 read-only", v, 32'h0000_00C0);
    ext_irq = '0;
    step();

    // source mapping
    pci_irq[13] = 1;
    step();
    rd(3'd5, v); chk("R11 devfn13 to line1", v, 32'h0000_0002);
    pci_irq = '0; pci_irq[30] = 1;
    step();
    rd(3'd5, v); chk("R11 devfn30 to line3", v, 32'h0000_0008);
    pci_irq = '0; pci_irq[7] = 1;
    step();
    rd(3'd5, v); chk("R11 devfn7 to line0", v, 32'h0000_0001);
    pci_irq = '0; serial_irq = 1;
    step();
    rd(3'd5, v); chk("R11 serial to line10", v, 32'h0000_0400);
    serial_irq = 0;
    repeat (20) step();
    chk("R6 drained", {31'd0, msg_req}, 32'd0);
    rd(3'd4, v);

    // random phase against bench model
    m_mask = NL'($urandom);
    m_sel  = NL'($urandom);
    m_t0   = $urandom;
    m_t1   = $urandom;
    wr(3'd2, wider(m_mask));
    wr(3'd3, wider(m_sel));
    wr(3'd0, m_t0);
    wr(3'd1, m_t1);
    m_live = '0; m_pend = '0; m_send = '0; m_req = 0;
    m_addr = '0; m_data = '0;
    for (int i = 0; i < 600; i++) begin
      logic [NL-1:0] l;
      logic a;
      chk("R6 R10 random req", {31'd0, msg_req}, {31'd0, m_req});
      if (m_req) begin
        chk("R7 R8 random addr", msg_addr, m_addr);
        chk("R8 random data", msg_data, m_data);
      end
      l = ext_irq ^ NL'($urandom & $urandom);
      a = ($urandom % 3) != 0;
      ext_irq = l;
      ack = a;
      @(posedge clk);
      model_edge(l, a);
      @(negedge clk);
    end
    rd(3'd4, v); chk("R2 random pend", v, wider(m_pend));
    rd(3'd5, v); chk("R2 random live", v, wider(m_live));

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule